// File: doc/BRIEF.md
# Dual-Mode Vertical Countdown Synchronizer

The block produces vertical and horizontal deflection timing from a clock that runs at twice the horizontal line rate. Each enabled clock tick advances a field counter. The block also toggles a horizontal drive output, so that output runs at half the tick rate. A vertical pulse of fixed width starts every field.

Two modes decide where a field ends.

- **Counting mode:** the field is always 525 ticks long, whatever the incoming sync does.
- **Sync mode:** an incoming vertical sync edge that falls inside an acceptance window ends the field. If no sync arrives, the window closes and the field ends there, so the output free-runs.

A sync is called coincident when it is accepted exactly at the field-count terminal value. A small run counter tracks whether successive fields agree with the current mode. The mode flips only after eight such fields in a row, which keeps noise from causing mode changes.

The host supplies a one-cycle clock enable per tick and a raw, asynchronous sync level. The block returns the vertical pulse, the horizontal drive and a flag showing the active mode.

Top module: `field_countdown_sync`

## Requirements
- R1: After reset the vertical pulse, horizontal drive and mode flag are all 0 (0 means counting mode). The first vertical pulse rises on the 525th enabled tick after reset.
- R2: The horizontal drive inverts on every enabled tick. While clk_en is low, neither the outputs nor the field count change.
- R3: In counting mode, consecutive vertical pulses start exactly 525 ticks apart, wherever a sync arrives.
- R4: Each vertical pulse stays high for exactly 16 ticks, counted from the tick that starts it.
- R5: A sync edge is accepted only under two conditions. The field count must be 512 or more on the tick that evaluates the edge. The edge must also be evaluated at the first enabled tick that comes at least three clocks after the edge.
- R6: In sync mode, a sync accepted when the field count is K (512 ≤ K ≤ 543) ends the field. The field is then K+1 ticks long.
- R7: In sync mode, a field with no accepted sync ends at count 543, so it lasts 544 ticks. A sync evaluated below count 512 does not shorten the field.
- R8: The block leaves counting mode after eight consecutive fields that had no coincident sync. A coincident sync is a sync accepted when the field count is 524. A coincident field breaks the run.
- R9: The block leaves sync mode after eight consecutive fields that end on a coincident sync. Any other field end breaks the run.
- R10: The mode flag changes only on the tick at which a vertical pulse starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | One-cycle tick at twice the line rate |
| vsync_in | input | 1 | Raw vertical sync level (asynchronous) |
| vpulse_out | output | 1 | Vertical deflection pulse |
| hdrive_out | output | 1 | Horizontal drive, half the tick rate |
| sync_mode_out | output | 1 | 1 in sync mode, 0 in counting mode |

## Verification
The hardest situation to reach from the ports is the eighth field of an agreeing run that follows a broken run. Reaching it takes thousands of ticks, each with a sync edge placed on one exact count, and the edge must clear the synchronizer latency. The stimulus times each sync by counting ticks from the last pulse. It raises the sync level three clocks before the tick that should evaluate it. To break runs on purpose, it places a sync early in the window and another beside the terminal count. It then checks that the mode flips only on the eighth field of a clean run.

// File: rtl/vcd_pkg.sv
package vcd_pkg;

    typedef enum logic {
        MODE_COUNT = 1'b0,
        MODE_SYNC  = 1'b1
    } vmode_e;

    localparam int DEF_CNT_W     = 10;
    localparam int DEF_FIELD_LEN = 525;
    localparam int DEF_WIN_OPEN  = 512;
    localparam int DEF_WIN_CLOSE = 544;
    localparam int DEF_PULSE_LEN = 16;
    localparam int DEF_HYST_W    = 3;

endpackage

// File: rtl/vsync_capture.sv
module vsync_capture #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic tick,
    output logic armed
);

    // Synchronizer stages followed by one history stage for edge detection.
    typedef struct packed {
        logic [STAGES:0] chain;
        logic            arm;
    } cap_t;

    cap_t cap_d, cap_q;
    logic rise;

    always_comb begin
        cap_d       = cap_q;
        cap_d.chain = {cap_q.chain[STAGES-1:0], sync_in};
        rise        = cap_q.chain[STAGES-1] & ~cap_q.chain[STAGES];
        // An edge is held until the next enabled tick consumes it.
        cap_d.arm   = rise | (cap_q.arm & ~tick);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign armed = cap_q.arm;

endmodule

// File: rtl/mode_hysteresis.sv
module mode_hysteresis
    import vcd_pkg::*;
#(
    parameter int HYST_W = DEF_HYST_W
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   field_end,
    input  logic   coincident,
    output vmode_e mode
);

    localparam logic [HYST_W-1:0] RUN_FULL = '1;

    typedef struct packed {
        logic [HYST_W-1:0] run;
        vmode_e            mode;
    } hys_t;

    hys_t hys_d, hys_q;
    logic agree;

    always_comb begin
        hys_d = hys_q;
        // A field agrees when it argues for leaving the present mode.
        agree = (hys_q.mode == MODE_COUNT) ? ~coincident : coincident;
        if (field_end) begin
            if (!agree) begin
                hys_d.run = '0;
            end else if (hys_q.run == RUN_FULL) begin
                hys_d.run  = '0;
                hys_d.mode = (hys_q.mode == MODE_COUNT) ? MODE_SYNC : MODE_COUNT;
            end else begin
                hys_d.run = hys_q.run + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hys_q <= '{run: '0, mode: MODE_COUNT};
        else        hys_q <= hys_d;
    end

    assign mode = hys_q.mode;

endmodule

// File: rtl/field_countdown_sync.sv
module field_countdown_sync
    import vcd_pkg::*;
#(
    parameter int CNT_W       = DEF_CNT_W,
    parameter int FIELD_LEN   = DEF_FIELD_LEN,
    parameter int WIN_OPEN    = DEF_WIN_OPEN,
    parameter int WIN_CLOSE   = DEF_WIN_CLOSE,
    parameter int PULSE_LEN   = DEF_PULSE_LEN,
    parameter int HYST_W      = DEF_HYST_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic vsync_in,
    output logic vpulse_out,
    output logic hdrive_out,
    output logic sync_mode_out
);

    localparam logic [CNT_W-1:0] CNT_TERM  = CNT_W'(FIELD_LEN - 1);
    localparam logic [CNT_W-1:0] CNT_OPEN  = CNT_W'(WIN_OPEN);
    localparam logic [CNT_W-1:0] CNT_SHUT  = CNT_W'(WIN_CLOSE - 1);
    localparam logic [CNT_W-1:0] CNT_PEND  = CNT_W'(PULSE_LEN - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             vpulse;
        logic             hdrive;
    } core_t;

    core_t  core_d, core_q;
    vmode_e mode;
    logic   armed;
    logic   accepted;
    logic   fire;
    logic   coincident;
    logic [CNT_W-1:0] cnt_now;

    vsync_capture #(.STAGES(SYNC_STAGES)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (vsync_in),
        .tick    (clk_en),
        .armed   (armed)
    );

    mode_hysteresis #(.HYST_W(HYST_W)) u_hyst (
        .clk        (clk),
        .rst_n      (rst_n),
        .field_end  (fire),
        .coincident (coincident),
        .mode       (mode)
    );

    always_comb begin
        core_d     = core_q;
        accepted   = clk_en & armed & (core_q.cnt >= CNT_OPEN);
        coincident = accepted & (core_q.cnt == CNT_TERM);
        if (mode == MODE_COUNT)
            fire = clk_en & (core_q.cnt == CNT_TERM);
        else
            fire = accepted | (clk_en & (core_q.cnt == CNT_SHUT));

        if (clk_en) begin
            core_d.hdrive = ~core_q.hdrive;
            core_d.cnt    = core_q.cnt + 1'b1;
            if (core_q.cnt == CNT_PEND)
                core_d.vpulse = 1'b0;
        end
        if (fire) begin
            core_d.cnt    = '0;
            core_d.vpulse = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign cnt_now       = core_q.cnt;
    assign vpulse_out    = core_q.vpulse;
    assign hdrive_out    = core_q.hdrive;
    assign sync_mode_out = (mode == MODE_SYNC);

endmodule

// File: rtl/field_countdown_sync_chk.sv
module field_countdown_sync_chk #(
    parameter int CNT_W     = 10,
    parameter int FIELD_LEN = 525,
    parameter int WIN_CLOSE = 544
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clk_en,
    input logic             vpulse,
    input logic             hdrive,
    input logic             mode,
    input logic [CNT_W-1:0] cnt
);

    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !mode |-> (int'(cnt) <= FIELD_LEN - 1));

    a_r7_sync_bound: assert property (@(posedge clk) disable iff (!rst_n)
        mode |-> (int'(cnt) <= WIN_CLOSE - 1));

    a_r2_hdrive_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |=> (hdrive != $past(hdrive)));

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(cnt) && $stable(hdrive) && $stable(vpulse)));

    a_r10_mode_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode) |-> $rose(vpulse));

    a_r4_pulse_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vpulse) |-> (cnt == '0));

endmodule

bind field_countdown_sync field_countdown_sync_chk #(
    .CNT_W     (CNT_W),
    .FIELD_LEN (FIELD_LEN),
    .WIN_CLOSE (WIN_CLOSE)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .clk_en (clk_en),
    .vpulse (vpulse_out),
    .hdrive (hdrive_out),
    .mode   (sync_mode_out),
    .cnt    (cnt_now)
);

// File: tb/field_countdown_sync_test.sv
`timescale 1ns/1ps
module field_countdown_sync_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_en = 1'b0;
    logic vsync = 1'b0;
    logic vpulse, hdrive, smode;

    int checks = 0;
    int fails = 0;
    int tick_ctr = 0;
    int last_rise = 0;
    bit prev_v = 1'b0;
    event tick_done;

    typedef struct {
        int    len;
        bit    mode;
        string req;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    field_countdown_sync uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .clk_en        (clk_en),
        .vsync_in      (vsync),
        .vpulse_out    (vpulse),
        .hdrive_out    (hdrive),
        .sync_mode_out (smode)
    );

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // One enabled tick; optionally raises sync early enough to be evaluated by it.
    task automatic tick(bit s);
        vsync <= s;
        @(negedge clk);
        @(negedge clk);
        vsync <= 1'b0;
        @(negedge clk);
        clk_en <= 1'b1;
        @(negedge clk);
        clk_en <= 1'b0;
        tick_ctr++;
        -> tick_done;
    endtask

    // Driver: runs one field, sync evaluated at count k (k < 0: none).
    task automatic field(int k, int exp_len, bit exp_mode, string req);
        exp_t e;
        e.len = exp_len;
        e.mode = exp_mode;
        e.req = req;
        exp_q.push_back(e);
        for (int i = 1; i <= exp_len; i++)
            tick(k >= 0 && i == k + 1);
    endtask

    // Monitor / scoreboard.
    initial begin
        forever begin
            @(tick_done);
            if (tick_ctr <= 8 || tick_ctr % 100 == 0)
                check(hdrive == tick_ctr[0], "R2", "hdrive after tick", int'(hdrive), int'(tick_ctr[0]));
            if (vpulse && !prev_v) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected pulse at tick", tick_ctr, -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(tick_ctr - last_rise == e.len, e.req, "field length",
                          tick_ctr - last_rise, e.len);
                    check(smode == e.mode, "R10", "mode at pulse start", int'(smode), int'(e.mode));
                end
                last_rise = tick_ctr;
            end
            if (!vpulse && prev_v)
                check(tick_ctr - last_rise == 16, "R4", "pulse width", tick_ctr - last_rise, 16);
            prev_v = vpulse;
        end
    end

    initial begin
        #900us;
        check(1'b0, "WDOG", "watchdog expired at tick", tick_ctr, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(vpulse == 1'b0, "R1", "vpulse in reset", int'(vpulse), 0);
        check(hdrive == 1'b0, "R1", "hdrive in reset", int'(hdrive), 0);
        check(smode == 1'b0, "R1", "mode in reset", int'(smode), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(hdrive == 1'b0 && vpulse == 1'b0, "R2", "outputs while idle",
              int'({hdrive, vpulse}), 0);

        // Counting mode: first field from reset, then a run broken by coincidence (R8).
        field(-1, 525, 1'b0, "R1");
        for (int f = 0; f < 4; f++) field(-1, 525, 1'b0, "R3");
        field(524, 525, 1'b0, "R8");       // coincident: clears run
        field(518, 525, 1'b0, "R5");       // accepted, not coincident: field unchanged
        for (int f = 0; f < 6; f++) field(-1, 525, 1'b0, "R8");
        field(-1, 525, 1'b1, "R8");        // eighth non-coincident field flips

        // Sync mode.
        field(-1, 544, 1'b1, "R7");        // free-run
        field(520, 521, 1'b1, "R6");       // window sync ends field
        field(500, 544, 1'b1, "R5");       // early sync ignored
        for (int f = 0; f < 7; f++) field(524, 525, 1'b1, "R9");
        field(530, 531, 1'b1, "R9");       // non-coincident breaks run
        for (int f = 0; f < 7; f++) field(524, 525, 1'b1, "R9");
        field(524, 525, 1'b0, "R9");       // eighth coincident field flips back

        field(-1, 525, 1'b0, "R3");
        for (int i = 0; i < 20; i++) tick(1'b0);
        check(exp_q.size() == 0, "R3", "unconsumed expected pulses", exp_q.size(), 0);
        check(smode == 1'b0, "R9", "final mode", int'(smode), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule